// File: doc/BRIEF.md
# Sound Coprocessor Interval Timer Block

This block sits on the I/O page of an 8-bit sound coprocessor. The CPU reaches it over a byte-wide register bus. The bus carries a control byte and three target bytes, and it reads back three 4-bit event counters. Each of the three interval timers is armed by its own bit in the control byte. An armed timer counts strobes on its tick input. Each time its private count reaches the latched target, the private count folds back to zero and the event counter steps up by one. Software polls the event counters, and each poll empties the counter it reads.

The control byte has two more duties. Two bits each produce a one-cycle clear pulse for a pair of host mailbox ports. The top bit decides whether the 64-byte boot ROM or plain RAM answers in the top 64 bytes of the address space. The block only supplies the flag that selects between them. The mailbox ports, the RAM array and the ROM contents are outside the block.

Top module: `snd_tmr_top`

## Requirements
- R1: After a synchronous reset, the control byte reads 0x80 at offset 0xF1, `rom_visible` is 1, all timers are stopped, every event counter reads 0 and both clear pulses are low.
- R2: A control write that moves timer i's arm bit (bit i, i = 0..2) from 0 to 1 zeroes that timer's private count and event counter. The same write latches the target byte held at that moment as the new period.
- R3: A control write that leaves an arm bit at 1 when it was already 1 does not disturb that timer's private count, event counter or period.
- R4: A latched target of 0 gives a period of 256 ticks.
- R5: An armed timer with period P steps its event counter once every P ticks. Timers 0 and 1 count `tick_slow` and timer 2 counts `tick_fast`.
- R6: Event counters are 4 bits wide and wrap from 15 to 0.
- R7: A read returns its data on `bus_rdata` in the cycle after `bus_rd` and holds it until the next read. A read of an event counter (offsets 0xFD, 0xFE, 0xFF for timers 0, 1, 2; data in bits 3:0, upper bits 0) zeroes that counter. If the period completes in the same cycle as the read, the counter becomes 1 instead.
- R8: A control write with bit 4 set raises `clr_ports_lo` for exactly the next cycle. A write with bit 5 set does the same for `clr_ports_hi`. No other write raises either pulse.
- R9: `rom_visible` follows bit 7 of the last control write, starting one cycle after that write.
- R10: A stopped timer ignores its tick input, and its event counter keeps its value.
- R11: Writing a target byte (offsets 0xFA, 0xFB, 0xFC for timers 0, 1, 2) while the timer is armed leaves its period unchanged until the next 0-to-1 arm transition.
- R12: Target bytes read back their last written value. The control byte reads back the full last written byte. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | 8 | Register offset within the I/O page |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tick_slow | input | 1 | One-cycle count strobe for timers 0 and 1 |
| tick_fast | input | 1 | One-cycle count strobe for timer 2 |
| clr_ports_lo | output | 1 | Clear pulse for mailbox ports 0 and 1 |
| clr_ports_hi | output | 1 | Clear pulse for mailbox ports 2 and 3 |
| rom_visible | output | 1 | 1 selects the boot ROM over RAM in the top 64 bytes |

## Verification
The hardest case to reach is a read of an event counter in the very cycle that the timer's period completes. To get there, the bench gives timer 2 a period of one tick and holds `tick_fast` high during the read cycle, so a fold is certain in that cycle. The outcome is then measured by a second read. The other delicate cases are whether an arm write restarts the timer, and whether a new target takes effect. For these, the bench runs the private count to a known mid-period point, performs the rewrite, and issues a tick count that gives a different counter value depending on whether the timer restarted. A behavioural model runs in step with the design and compares the outputs on every clock.

// File: rtl/snd_tmr_pkg.sv
package snd_tmr_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'hF1;
  localparam logic [ADDR_W-1:0] OFS_TGT_BASE = 8'hFA;
  localparam logic [ADDR_W-1:0] OFS_CNT_BASE = 8'hFD;
  localparam logic [DATA_W-1:0] CTRL_RESET   = 8'h80;
  localparam int BIT_CLR_LO = 4;
  localparam int BIT_CLR_HI = 5;
  localparam int BIT_ROM    = 7;
endpackage

// File: rtl/snd_tmr_chan.sv
module snd_tmr_chan #(
  parameter int DIV_W = 8,
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] tgt,
  input  logic             tick,
  input  logic             rd_clr,
  output logic [OUT_W-1:0] out_q
);
  localparam int LAT_W = DIV_W + 1;
  localparam logic [LAT_W-1:0] FULL = LAT_W'(1) << DIV_W;

  logic [DIV_W-1:0] inner_q;
  logic [LAT_W-1:0] lat_q;
  logic             hit;

  assign hit = en && tick && (({1'b0, inner_q} + LAT_W'(1)) == lat_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      inner_q <= '0;
      lat_q   <= FULL;
      out_q   <= '0;
    end else if (restart) begin
      inner_q <= '0;
      lat_q   <= (tgt == '0) ? FULL : {1'b0, tgt};
      out_q   <= '0;
    end else begin
      if (en && tick)
        inner_q <= hit ? '0 : inner_q + DIV_W'(1);
      if (rd_clr)
        out_q <= hit ? OUT_W'(1) : '0;
      else if (hit)
        out_q <= out_q + OUT_W'(1);
    end
  end

  assert_inner_below_period_R4: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, inner_q} < lat_q));

  assert_restart_zeroes_R2: assert property (@(posedge clk) disable iff (rst)
    restart |=> (out_q == '0 && inner_q == '0));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (!en && !restart && !rd_clr) |=> ($stable(out_q) && $stable(inner_q)));

  assert_step_by_one_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && !restart && !rd_clr) |=> (out_q == $past(out_q) + OUT_W'(1)));
endmodule

// File: rtl/snd_tmr_regs.sv
module snd_tmr_regs
  import snd_tmr_pkg::*;
#(
  parameter int N_TMR = 3,
  parameter int OUT_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  input  logic [N_TMR-1:0][OUT_W-1:0]   cnt,
  output logic [DATA_W-1:0]             ctrl_q,
  output logic [N_TMR-1:0][DATA_W-1:0]  tgt_q,
  output logic [N_TMR-1:0]              restart,
  output logic [N_TMR-1:0]              rd_clr,
  output logic [DATA_W-1:0]             rdata_q,
  output logic                          clr_lo_q,
  output logic                          clr_hi_q
);
  logic             ctrl_wr;
  logic [DATA_W-1:0] rd_mux;

  assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFS_CTRL) rd_mux = ctrl_q;
    for (int i = 0; i < N_TMR; i++) begin
      if (bus_addr == OFS_TGT_BASE + ADDR_W'(i)) rd_mux = tgt_q[i];
      if (bus_addr == OFS_CNT_BASE + ADDR_W'(i)) rd_mux = DATA_W'(cnt[i]);
    end
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_dec
    assign restart[g] = ctrl_wr && bus_wdata[g] && !ctrl_q[g];
    assign rd_clr[g]  = bus_rd && (bus_addr == OFS_CNT_BASE + ADDR_W'(g));

    always_ff @(posedge clk) begin
      if (rst)
        tgt_q[g] <= '0;
      else if (bus_wr && bus_addr == OFS_TGT_BASE + ADDR_W'(g))
        tgt_q[g] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RESET;
      rdata_q  <= '0;
      clr_lo_q <= 1'b0;
      clr_hi_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata;
      if (bus_rd) rdata_q <= rd_mux;
      clr_lo_q <= ctrl_wr && bus_wdata[BIT_CLR_LO];
      clr_hi_q <= ctrl_wr && bus_wdata[BIT_CLR_HI];
    end
  end

  assert_clear_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && bus_wdata[BIT_CLR_LO]) |=> clr_lo_q);

  assert_no_stray_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_wr && bus_wdata[BIT_CLR_HI]) |=> !clr_hi_q);

  assert_ctrl_follows_R9: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (ctrl_q == $past(bus_wdata)));

  assert_one_restart_source_R2: assert property (@(posedge clk) disable iff (rst)
    (restart != '0) |-> ctrl_wr);
endmodule

// File: rtl/snd_tmr_top.sv
module snd_tmr_top
  import snd_tmr_pkg::*;
#(
  parameter int   N_TMR     = 3,
  parameter int   DIV_W     = 8,
  parameter int   OUT_W     = 4,
  parameter logic [N_TMR-1:0] FAST_MASK = 3'b100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_slow,
  input  logic              tick_fast,
  output logic              clr_ports_lo,
  output logic              clr_ports_hi,
  output logic              rom_visible
);
  logic [DATA_W-1:0]            ctrl_q;
  logic [N_TMR-1:0][DATA_W-1:0] tgt_q;
  logic [N_TMR-1:0]             restart;
  logic [N_TMR-1:0]             rd_clr;
  logic [N_TMR-1:0][OUT_W-1:0]  cnt;

  snd_tmr_regs #(.N_TMR(N_TMR), .OUT_W(OUT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cnt      (cnt),
    .ctrl_q   (ctrl_q),
    .tgt_q    (tgt_q),
    .restart  (restart),
    .rd_clr   (rd_clr),
    .rdata_q  (bus_rdata),
    .clr_lo_q (clr_ports_lo),
    .clr_hi_q (clr_ports_hi)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    logic tick_sel;
    if (FAST_MASK[g]) begin : g_fast
      assign tick_sel = tick_fast;
    end else begin : g_slow
      assign tick_sel = tick_slow;
    end

    snd_tmr_chan #(.DIV_W(DIV_W), .OUT_W(OUT_W)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .en     (ctrl_q[g]),
      .restart(restart[g]),
      .tgt    (tgt_q[g][DIV_W-1:0]),
      .tick   (tick_sel),
      .rd_clr (rd_clr[g]),
      .out_q  (cnt[g])
    );
  end

  assign rom_visible = ctrl_q[BIT_ROM];

  assert_rom_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_CTRL) |=> (rom_visible == $past(bus_wdata[BIT_ROM])));
endmodule

// File: tb/sim_snd_tmr_top.sv
`timescale 1ns/1ps
module sim_snd_tmr_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tick_slow = 1'b0, tick_fast = 1'b0;
  logic       clr_ports_lo, clr_ports_hi, rom_visible;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  snd_tmr_top u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_slow(tick_slow), .tick_fast(tick_fast),
    .clr_ports_lo(clr_ports_lo), .clr_ports_hi(clr_ports_hi),
    .rom_visible(rom_visible)
  );

  // behavioural reference
  int m_ctrl, m_rdata, m_lo, m_hi;
  int m_tgt[3], m_per[3], m_in[3], m_out[3];

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 'h80; m_rdata = 0; m_lo = 0; m_hi = 0;
      for (int i = 0; i < 3; i++) begin
        m_tgt[i] = 0; m_per[i] = 256; m_in[i] = 0; m_out[i] = 0;
      end
    end else begin
      automatic bit cw = bus_wr && bus_addr == 8'hF1;
      if (bus_rd) begin
        automatic int v = 0;
        if (bus_addr == 8'hF1) v = m_ctrl;
        for (int i = 0; i < 3; i++) begin
          if (bus_addr == 8'hFA + i) v = m_tgt[i];
          if (bus_addr == 8'hFD + i) v = m_out[i];
        end
        m_rdata = v;
      end
      for (int i = 0; i < 3; i++) begin
        automatic bit en = m_ctrl[i];
        automatic bit tk = (i == 2) ? tick_fast : tick_slow;
        automatic bit hit = 0;
        if (cw && bus_wdata[i] && !en) begin
          m_in[i] = 0; m_out[i] = 0;
          m_per[i] = (m_tgt[i] == 0) ? 256 : m_tgt[i];
        end else begin
          if (en && tk) begin
            if (m_in[i] + 1 == m_per[i]) begin m_in[i] = 0; hit = 1; end
            else m_in[i] = m_in[i] + 1;
          end
          if (bus_rd && bus_addr == 8'hFD + i) m_out[i] = hit ? 1 : 0;
          else if (hit) m_out[i] = (m_out[i] + 1) % 16;
        end
      end
      m_lo = cw && bus_wdata[4];
      m_hi = cw && bus_wdata[5];
      if (cw) m_ctrl = bus_wdata;
      for (int i = 0; i < 3; i++)
        if (bus_wr && bus_addr == 8'hFA + i) m_tgt[i] = bus_wdata;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R7 rdata vs model", bus_rdata, m_rdata);
      chk("R9 rom_visible vs model", rom_visible, m_ctrl[7]);
      chk("R8 clr_ports_lo vs model", clr_ports_lo, m_lo);
      chk("R8 clr_ports_hi vs model", clr_ports_hi, m_hi);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input bit with_fast, output int v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; tick_fast = with_fast;
    @(negedge clk);
    bus_rd = 1'b0; tick_fast = 1'b0;
    v = bus_rdata;
  endtask

  task automatic ticks(input bit s, input bit f, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_slow = s; tick_fast = f;
    end
    @(negedge clk);
    tick_slow = 1'b0; tick_fast = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    @(negedge clk);
    chk("R1 rom_visible after reset", rom_visible, 1);
    chk("R1 clr_ports_lo after reset", clr_ports_lo, 0);
    rd(8'hF1, 0, v); chk("R1 ctrl reads 0x80", v, 'h80);
    rd(8'hFD, 0, v); chk("R1 counter 0 idle", v, 0);
    ticks(1, 1, 5);
    rd(8'hFF, 0, v); chk("R1 timer 2 stopped after reset", v, 0);

    // R5 basic counting, slow and fast strobes
    wr(8'hFA, 8'd4); wr(8'hFB, 8'd0); wr(8'hFC, 8'd3);
    wr(8'hF1, 8'h87);
    ticks(1, 0, 8);
    ticks(0, 1, 7);
    rd(8'hFD, 0, v); chk("R5 timer 0 after 8 slow ticks, period 4", v, 2);
    rd(8'hFD, 0, v); chk("R7 counter emptied by read", v, 0);
    rd(8'hFF, 0, v); chk("R5 timer 2 after 7 fast ticks, period 3", v, 2);

    // R4 period 256, R6 wrap on timer 0
    ticks(1, 0, 248);
    rd(8'hFE, 0, v); chk("R4 target 0 gives one event per 256 ticks", v, 1);
    rd(8'hFD, 0, v); chk("R6 62 events wrap to 14", v, 14);

    // R3 rewriting armed bit is harmless
    ticks(1, 0, 2);
    wr(8'hF1, 8'h87);
    ticks(1, 0, 2);
    rd(8'hFD, 0, v); chk("R3 no restart on repeated arm", v, 1);

    // R11 target rewrite while armed has no effect
    wr(8'hFA, 8'd2);
    ticks(1, 0, 2);
    rd(8'hFD, 0, v); chk("R11 period still 4 after target write", v, 0);

    // R2 restart on 0-to-1 latches new target
    wr(8'hF1, 8'h86);
    wr(8'hF1, 8'h87);
    ticks(1, 0, 4);
    rd(8'hFD, 0, v); chk("R2 restart picks period 2", v, 2);

    // R6 wrap on timer 2, read coinciding with fold (R7)
    wr(8'hFC, 8'd1);
    wr(8'hF1, 8'h83);
    wr(8'hF1, 8'h87);
    ticks(0, 1, 17);
    rd(8'hFF, 1, v); chk("R6 17 events wrap to 1", v, 1);
    rd(8'hFF, 0, v); chk("R7 fold during read leaves 1", v, 1);

    // R10 stopped timer ignores ticks
    ticks(0, 1, 3);
    wr(8'hF1, 8'h83);
    ticks(0, 1, 5);
    rd(8'hFF, 0, v); chk("R10 stopped timer keeps 3", v, 3);

    // R8 clear pulses
    wr(8'hF1, 8'h93);
    chk("R8 lo pulse after bit 4 write", clr_ports_lo, 1);
    chk("R8 hi quiet on bit 4 write", clr_ports_hi, 0);
    @(negedge clk);
    chk("R8 lo pulse lasts one cycle", clr_ports_lo, 0);
    wr(8'hF1, 8'hA3);
    chk("R8 hi pulse after bit 5 write", clr_ports_hi, 1);
    wr(8'hFA, 8'hFF);
    chk("R8 no pulse on target write", clr_ports_hi, 0);

    // R9 ROM flag and R12 readback
    wr(8'hF1, 8'h03);
    chk("R9 rom hidden after bit 7 cleared", rom_visible, 0);
    rd(8'hF1, 0, v); chk("R12 ctrl readback", v, 'h03);
    rd(8'hFA, 0, v); chk("R12 target 0 readback", v, 'hFF);
    rd(8'hFC, 0, v); chk("R12 target 2 readback", v, 1);
    rd(8'hF0, 0, v); chk("R12 unmapped reads 0", v, 0);
    wr(8'hF1, 8'h83);
    chk("R9 rom visible again", rom_visible, 1);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule